// File: doc/BRIEF.md
# Write-Through Snooping Data Cache With Invalidation

This block is a small direct-mapped data cache for one processor that shares a broadcast bus with other agents. Every processor write is passed straight to memory over the bus, so memory always holds current data, and a read that misses fetches its word from memory. The cache watches the write transactions that other agents place on the bus. When one of them names an address that the cache holds, the line's valid bit is cleared, so the stale copy cannot be read again.

A line holds one data word. The word address is split into a line index (its low `$clog2(LINES)` bits) and a tag (the rest). The processor port uses a valid/ready handshake. The processor raises `cpu_valid` with the command, address and write data and holds all of them steady until it sees `cpu_ready` high at a rising edge. `cpu_ready` is high for exactly that one cycle. The processor may place a new request in the very next cycle. The bus master port asks for ownership with `bus_req` and keeps it high until it sees `bus_gnt`. A read holds the bus until the memory side returns the word with `bus_rvalid`. The snoop input carries only the transactions of other agents. It needs no handshake, because the cache accepts one snoop in every cycle.

Top module: `snoop_wt_cache`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_ready` and `bus_req` are low. Every line is invalid, so the first read of any address is a miss.
- R2: On a read miss, the cycle after the request `bus_req` is high with `bus_cmd`=0 (read) and `bus_addr` equal to the request address. After `bus_gnt`, the cache waits for `bus_rvalid`. In that same cycle `cpu_ready` is high and `cpu_rdata` equals `bus_rdata`.
- R3: A read whose line is valid and whose tag matches raises `cpu_ready` in the request cycle, with the stored word on `cpu_rdata`. No bus request is made.
- R4: On a write, the cycle after the request `bus_req` is high with `bus_cmd`=1 (write), and `bus_addr`/`bus_wdata` carry the request. They stay unchanged and `cpu_ready` stays low until `bus_gnt`. `cpu_ready` is high in the cycle in which `bus_gnt` is high.
- R5: A write to a cached address also updates the local copy, and the line stays valid. A write to an address that is not cached does not allocate a line, so a later read of that address misses.
- R6: A snooped write (`snp_valid`=1, `snp_write`=1) whose address matches a valid line clears that line. A read issued in the same cycle as such a snoop to the same address is handled as a miss.
- R7: A snooped read (`snp_write`=0) leaves the cache unchanged. So does a snooped write to the same index with a different tag. A later read of the cached address still hits.
- R8: A snooped write whose address matches an outstanding read miss, at any point from the request up to and including the data cycle, still delivers the returned word to the processor. The word is not installed, so the next read of that address misses again.
- R9: Snoop lookups use their own copy of the tags. A snoop to a different line in the same cycle does not delay a read hit.
- R10: A completed fill replaces the line at its index, tag included. A read of the previous address at that index then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd | output | 1 | 0 = read, 1 = write |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rvalid | input | 1 | Read data returned from memory |
| bus_rdata | input | DATA_W | Returned read data |
| snp_valid | input | 1 | Another agent's bus transaction is visible |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped word address |

## Verification
The bench builds the cache with ADDR_W=8, DATA_W=16 and LINES=8. It keeps its traffic in the lowest 32 words, so four tags compete for every index. Conflict replacements, write hits and snoop hits on cached lines therefore occur often. Grant and data-return delays are drawn from a fixed seed and range from zero to a few cycles. This exercises the hold-until-grant rule and allows snoops to land both inside an outstanding fill and in the same cycle as a lookup.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WR     = 2'd1,
    ST_RDREQ  = 2'd2,
    ST_RDWAIT = 2'd3
  } swc_state_e;

  localparam logic CMD_RD = 1'b0;
  localparam logic CMD_WR = 1'b1;
endpackage

// File: rtl/swc_ram.sv
module swc_ram #(
  parameter int IDX_W = 6,
  parameter int W     = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rval
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[widx] <= wval;
  end

  assign rval = store_q[ridx];
endmodule

// File: rtl/swc_valid_bits.sv
module swc_valid_bits #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_vld,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_vld
);
  localparam int LINES = 2 ** IDX_W;

  logic [LINES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (clr_en) vld_q[clr_idx] <= 1'b0;
      if (set_en) vld_q[set_idx] <= 1'b1;
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign rb_vld = vld_q[rb_idx];

  // R6: a snoop hit clears the line unless a fill to that index wins
  assert_snoop_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !vld_q[$past(clr_idx)]);

  // R10: an install leaves its line valid
  assert_install_set_R10: assert property (@(posedge clk) disable iff (rst)
    set_en |=> vld_q[$past(set_idx)]);
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              snp_match,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              install,
  output logic              wr_update
);
  swc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_data_q;
  logic              fill_ok_q;
  logic              capture;

  assign lk_addr   = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;
  assign bus_addr  = req_addr_q;
  assign bus_wdata = req_data_q;

  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    cpu_rdata = arr_rdata;
    bus_req   = 1'b0;
    bus_cmd   = CMD_RD;
    install   = 1'b0;
    wr_update = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (cpu_we) begin
            capture = 1'b1;
            state_d = ST_WR;
          end else if (lk_hit && !snp_match) begin
            cpu_ready = 1'b1;
          end else begin
            capture = 1'b1;
            state_d = ST_RDREQ;
          end
        end
      end
      ST_WR: begin
        bus_req = 1'b1;
        bus_cmd = CMD_WR;
        if (bus_gnt) begin
          cpu_ready = 1'b1;
          wr_update = lk_hit;
          state_d   = ST_IDLE;
        end
      end
      ST_RDREQ: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        bus_req = 1'b1;
        if (bus_rvalid) begin
          cpu_ready = 1'b1;
          cpu_rdata = bus_rdata;
          install   = fill_ok_q && !snp_match;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      req_data_q <= '0;
      fill_ok_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        req_addr_q <= cpu_addr;
        req_data_q <= cpu_wdata;
        fill_ok_q  <= 1'b1;
      end else if ((state_q == ST_RDREQ || state_q == ST_RDWAIT) && snp_match) begin
        fill_ok_q <= 1'b0;
      end
    end
  end

  // R3: completion only answers a presented request
  assert_ready_valid_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> cpu_valid);

  // R4: a write completes only while the bus is owned
  assert_wr_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && cpu_we) |-> (bus_req && bus_gnt && bus_cmd == CMD_WR));

  // R4: the request stays up and unchanged until granted
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && state_q != ST_RDWAIT) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata)));

  // R2: a read that used the bus completes only with returned data
  assert_rd_data_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && !cpu_we && bus_req) |-> (bus_rvalid && cpu_rdata == bus_rdata));
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx, snp_idx;
  logic [TAG_W-1:0]  lk_tag, snp_tag;
  logic [IDX_W-1:0]  tag_ridx [2];
  logic [TAG_W-1:0]  tag_rval [2];
  logic              lk_vld, snp_vld, lk_hit, snp_hit, snp_match;
  logic              install, wr_update;
  logic [DATA_W-1:0] arr_rdata;

  assign lk_idx  = lk_addr[IDX_W-1:0];
  assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  // Copy 0 serves processor lookups, copy 1 serves snoop lookups.
  for (genvar g = 0; g < 2; g++) begin : g_tag
    assign tag_ridx[g] = (g == 0) ? lk_idx : snp_idx;
    swc_ram #(.IDX_W(IDX_W), .W(TAG_W)) u_tags (
      .clk  (clk),
      .we   (install),
      .widx (lk_idx),
      .wval (lk_tag),
      .ridx (tag_ridx[g]),
      .rval (tag_rval[g])
    );
  end

  swc_ram #(.IDX_W(IDX_W), .W(DATA_W)) u_data (
    .clk  (clk),
    .we   (install || wr_update),
    .widx (lk_idx),
    .wval (install ? bus_rdata : bus_wdata),
    .ridx (lk_idx),
    .rval (arr_rdata)
  );

  swc_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .set_en  (install),
    .set_idx (lk_idx),
    .clr_en  (snp_hit),
    .clr_idx (snp_idx),
    .ra_idx  (lk_idx),
    .ra_vld  (lk_vld),
    .rb_idx  (snp_idx),
    .rb_vld  (snp_vld)
  );

  assign lk_hit    = lk_vld && (tag_rval[0] == lk_tag);
  assign snp_hit   = snp_valid && snp_write && snp_vld && (tag_rval[1] == snp_tag);
  assign snp_match = snp_valid && snp_write && (snp_addr == lk_addr);

  swc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .arr_rdata  (arr_rdata),
    .snp_match  (snp_match),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .install    (install),
    .wr_update  (wr_update)
  );

  // R6: a read hit is never granted over a same-cycle snooped write to it
  assert_no_stale_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && !cpu_we && !bus_req) |-> !snp_match);
endmodule

// File: tb/snoop_wt_cache_tb.sv
module snoop_wt_cache_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_cmd;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rvalid = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic [AW-1:0] snp_addr = '0;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0]    mem [256];
  bit               mv  [NL];
  logic [AW-IW-1:0] mt  [NL];

  always #5 clk = ~clk;

  snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
    .snp_write(snp_write), .snp_addr(snp_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return mv[a[IW-1:0]] && (mt[a[IW-1:0]] == a[AW-1:IW]);
  endfunction

  function automatic void model_snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem[a] = d;
    if (model_hit(a)) mv[a[IW-1:0]] = 1'b0;
  endfunction

  // Other agents' traffic; a write also changes memory.
  task automatic do_snoop(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit wr);
    @(negedge clk);
    snp_valid = 1'b1; snp_write = wr; snp_addr = a;
    if (wr) model_snoop(a, d);
    @(posedge clk); #1;
    snp_valid = 1'b0; snp_write = 1'b0;
  endtask

  // mode: 0 plain, 1 same-cycle snoop write to same address,
  // 2 snoop write to same address during the fill, 3 same-cycle snoop elsewhere
  task automatic do_read(input logic [AW-1:0] a, input int mode, input string rq);
    bit            exp_hit;
    logic [AW-1:0] sa;
    logic [DW-1:0] rv;
    int            gd, wd;
    exp_hit = model_hit(a);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    if (mode == 1 || mode == 3) begin
      sa = (mode == 1) ? a : (a ^ 8'h01);
      snp_valid = 1'b1; snp_write = 1'b1; snp_addr = sa;
      model_snoop(sa, DW'($urandom));
      if (mode == 1) exp_hit = 1'b0;
    end
    #1;
    chk(cpu_ready == exp_hit, rq, int'(cpu_ready), int'(exp_hit));
    if (exp_hit) begin
      chk(cpu_rdata == mem[a], rq, int'(cpu_rdata), int'(mem[a]));
      @(posedge clk); #1;
      cpu_valid = 1'b0; snp_valid = 1'b0; snp_write = 1'b0;
    end else begin
      @(posedge clk); #1;
      snp_valid = 1'b0; snp_write = 1'b0;
      @(negedge clk);
      chk(bus_req && bus_cmd == 1'b0 && bus_addr == a, "R2 read request",
          int'({bus_req, bus_cmd, bus_addr}), int'({1'b1, 1'b0, a}));
      gd = $urandom % 3;
      for (int i = 0; i < gd; i++) begin
        @(negedge clk);
        chk(!cpu_ready && bus_req, "R2 wait grant", int'({bus_req, cpu_ready}), 2);
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      rv = mem[a];
      if (mode == 2) begin
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = a;
        model_snoop(a, DW'($urandom));
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0;
      end
      wd = $urandom % 3;
      for (int i = 0; i < wd; i++) begin
        chk(!cpu_ready && bus_req, "R2 hold during fill", int'({bus_req, cpu_ready}), 2);
        @(negedge clk);
      end
      if (mode != 2) rv = mem[a];
      bus_rvalid = 1'b1; bus_rdata = rv;
      #1;
      chk(cpu_ready == 1'b1, "R2 fill ready", int'(cpu_ready), 1);
      chk(cpu_rdata == rv, "R2 fill data", int'(cpu_rdata), int'(rv));
      @(posedge clk); #1;
      bus_rvalid = 1'b0; cpu_valid = 1'b0;
      if (mode != 2) begin
        mv[a[IW-1:0]] = 1'b1;
        mt[a[IW-1:0]] = a[AW-1:IW];
      end
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int gd;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(cpu_ready == 1'b0, "R4 no early ready", int'(cpu_ready), 0);
    @(negedge clk);
    chk(bus_req && bus_cmd == 1'b1 && bus_addr == a && bus_wdata == d, "R4 write request",
        int'({bus_req, bus_cmd, bus_addr, bus_wdata}), int'({1'b1, 1'b1, a, d}));
    gd = $urandom % 4;
    for (int i = 0; i < gd; i++) begin
      @(negedge clk);
      chk(bus_req && !cpu_ready && bus_addr == a && bus_wdata == d, "R4 hold until grant",
          int'({bus_req, cpu_ready}), 2);
    end
    bus_gnt = 1'b1;
    #1;
    chk(cpu_ready == 1'b1, "R4 ready at grant", int'(cpu_ready), 1);
    @(posedge clk); #1;
    bus_gnt = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0;
    mem[a] = d;
  endtask

  initial begin
    int s;
    int r;
    logic [AW-1:0] a;
    s = $urandom(32'd20240);
    for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
    for (int i = 0; i < NL; i++) begin mv[i] = 1'b0; mt[i] = '0; end

    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R1 reset outputs", int'({cpu_ready, bus_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R1 after reset", int'({cpu_ready, bus_req}), 0);

    do_read(8'h05, 0, "R1 first read misses");
    do_read(8'h05, 0, "R3 read hit");
    do_write(8'h05, 16'hBEEF);
    do_read(8'h05, 0, "R5 write hit updates copy");
    do_write(8'h0E, 16'h1234);
    do_read(8'h0E, 0, "R5 write miss no allocate");
    do_snoop(8'h05, 16'h7777, 1'b1);
    do_read(8'h05, 0, "R6 snoop write invalidates");
    do_snoop(8'h05, 16'h0, 1'b0);
    do_read(8'h05, 0, "R7 snoop read ignored");
    do_snoop(8'h0D, 16'h4242, 1'b1);
    do_read(8'h05, 0, "R7 same index other tag ignored");
    do_read(8'h05, 1, "R6 same-cycle snoop forces miss");
    do_read(8'h05, 3, "R9 snoop elsewhere does not delay hit");
    do_read(8'h15, 2, "R8 snoop during fill");
    do_read(8'h15, 0, "R8 cancelled fill not installed");
    do_read(8'h1D, 0, "R10 conflicting fill");
    do_read(8'h15, 0, "R10 previous line replaced");

    for (int n = 0; n < 400; n++) begin
      r = $urandom % 10;
      a = AW'($urandom % 32);
      if (r < 4)       do_read(a, 0, "R3 random read");
      else if (r < 6)  do_write(a, DW'($urandom));
      else if (r == 6) do_snoop(a, DW'($urandom), 1'b1);
      else if (r == 7) do_snoop(a, DW'($urandom), 1'b0);
      else if (r == 8) do_read(a, 1 + int'($urandom % 3), "R6 random snoop mix");
      else             do_read(a, 2, "R8 random fill cancel");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule